// File: doc/BRIEF.md
# Dual Latched Interval Timer

The block holds two 16-bit down-counters that share one clock enable and one byte-wide register port. Timer 1 owns a 16-bit reload latch. It runs either one-shot or free-running, chosen by a two-bit field in an 8-bit mode register. Timer 2 is a one-shot counter with its own latch. Software loads a timer by writing the low latch byte first. Writing the high byte then commits the full value and restarts the count.

When a timer counts down past zero it raises its interrupt flag. For that cycle it also gives a one-cycle set pulse, which a separate interrupt unit uses. Reading the counter's low byte acknowledges the flag, and so does writing a new high byte. Each clearing access gives a one-cycle clear pulse. The counters move only on cycles where `tick_en` is high, so the count rate is whatever the surrounding logic strobes.

Top module: `dual_interval_timer`

## Requirements
- R1: With mode register bits 7:6 equal to 01, timer 1 counts from its latch value L down through 0 to 0xFFFF. On the next tick it reloads L. Its flag therefore sets every L+2 ticks, the first time L+1 ticks after the load.
- R2: A write to address 0 or to address 2 replaces only the low byte of the timer 1 latch and leaves the timer 1 count unchanged. Address 2 reads back the latch low byte.
- R3: A write to address 1 stores the timer 1 latch high byte, clears the timer 1 flag and loads the count with the full latch (new high byte, stored low byte).
- R4: A write to address 3 stores the timer 1 latch high byte (read back at address 3) and clears the timer 1 flag. The count is left unchanged.
- R5: A read of address 0 returns the low byte of the timer 1 count and clears its flag. A read of address 1 returns the high byte and leaves the flag unchanged.
- R6: With any other value in bits 7:6, timer 1 sets its flag once per load, when it passes 0. It then keeps decrementing through the wrap without reloading and without setting the flag again.
- R7: Address 4 writes only the timer 2 latch low byte (read back at 8; the high byte reads at 9). A write to address 5 stores the high byte, clears the timer 2 flag and loads the count from the latch. The flag then sets once, L+1 ticks later, and the count keeps falling with no reload.
- R8: A read of address 4 returns the timer 2 count low byte and clears its flag. A read of address 5 returns the high byte and does not clear it.
- R9: After reset both latches and both counts are 0xFFFF, both flags are low, and the mode register is 0. Timer 2 stays unarmed until its first load.
- R10: Counts change only on cycles with `tick_en` high, or on a counter load.
- R11: A set pulse lasts one cycle and appears with the flag's rise. Every clearing access gives a one-cycle clear pulse. An expiry in the same cycle as an acknowledge leaves the flag set.
- R12: Read data is registered and updates only on a read. It shows the count as it was before that edge. Address 6 reads the mode register, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| irq_flag | output | 2 | Interrupt flags, bit 0 timer 1, bit 1 timer 2 |
| flag_set | output | 2 | One-cycle flag set pulses |
| flag_clr | output | 2 | One-cycle flag clear pulses |

## Verification
Both timers are swept over a range of small latch values. The tick at which the flag rises is compared with L+1, and the free-running reload gap with L+2, which separates a correct period from an off-by-one at either wrap point. A single-shot run lets the counter go all the way round the 16-bit range to show that no second flag and no reload happen. Byte-level accesses are also mixed to separate latch-only writes from loads and acknowledging reads from plain reads. One case puts an expiry and an acknowledge in the same cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_TMR = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_T1_CLO = 4'd0;
  localparam logic [ADDR_W-1:0] A_T1_CHI = 4'd1;
  localparam logic [ADDR_W-1:0] A_T1_LLO = 4'd2;
  localparam logic [ADDR_W-1:0] A_T1_LHI = 4'd3;
  localparam logic [ADDR_W-1:0] A_T2_CLO = 4'd4;
  localparam logic [ADDR_W-1:0] A_T2_CHI = 4'd5;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd6;
  localparam logic [ADDR_W-1:0] A_T2_LLO = 4'd8;
  localparam logic [ADDR_W-1:0] A_T2_LHI = 4'd9;

  // timer 1 run-mode field inside the mode register
  localparam int          MODE_MSB  = 7;
  localparam int          MODE_LSB  = 6;
  localparam logic [1:0]  MODE_CONT = 2'b01;
endpackage

// File: rtl/dit_access_decode.sv
module dit_access_decode #(
  parameter int DATA_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic                                      rd_en,
  input  logic [dit_pkg::ADDR_W-1:0]                addr,
  input  logic [dit_pkg::NUM_TMR-1:0][2*DATA_W-1:0] cnt,
  input  logic [dit_pkg::NUM_TMR-1:0][2*DATA_W-1:0] latch,
  input  logic [DATA_W-1:0]                         mode_q,
  output logic [dit_pkg::NUM_TMR-1:0]               wr_lo,
  output logic [dit_pkg::NUM_TMR-1:0]               wr_hi_load,
  output logic [dit_pkg::NUM_TMR-1:0]               wr_hi_latch,
  output logic [dit_pkg::NUM_TMR-1:0]               rd_ack,
  output logic                                      mode_wr,
  output logic [DATA_W-1:0]                         rd_data
);
  import dit_pkg::*;
  localparam int CNT_W = 2*DATA_W;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_lo       = '0;
    wr_hi_load  = '0;
    wr_hi_latch = '0;
    rd_ack      = '0;
    mode_wr     = 1'b0;
    if (wr_en) begin
      case (addr)
        A_T1_CLO, A_T1_LLO: wr_lo[0]       = 1'b1;
        A_T1_CHI:           wr_hi_load[0]  = 1'b1;
        A_T1_LHI:           wr_hi_latch[0] = 1'b1;
        A_T2_CLO:           wr_lo[1]       = 1'b1;
        A_T2_CHI:           wr_hi_load[1]  = 1'b1;
        A_MODE:             mode_wr        = 1'b1;
        default: ;
      endcase
    end
    if (rd_en) begin
      case (addr)
        A_T1_CLO: rd_ack[0] = 1'b1;
        A_T2_CLO: rd_ack[1] = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_T1_CLO: rd_mux = cnt[0][DATA_W-1:0];
      A_T1_CHI: rd_mux = cnt[0][CNT_W-1:DATA_W];
      A_T1_LLO: rd_mux = latch[0][DATA_W-1:0];
      A_T1_LHI: rd_mux = latch[0][CNT_W-1:DATA_W];
      A_T2_CLO: rd_mux = cnt[1][DATA_W-1:0];
      A_T2_CHI: rd_mux = cnt[1][CNT_W-1:DATA_W];
      A_MODE:   rd_mux = mode_q;
      A_T2_LLO: rd_mux = latch[1][DATA_W-1:0];
      A_T2_LHI: rd_mux = latch[1][CNT_W-1:DATA_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R12
  AST_MODE_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_MODE) |=> rd_data == $past(mode_q)); // R12
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int DATA_W      = 8,
  parameter bit CAN_CONT    = 1'b0,
  parameter bit RESET_ARMED = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  cont_mode,
  input  logic                  wr_lo,
  input  logic                  wr_hi_load,
  input  logic                  wr_hi_latch,
  input  logic                  ack,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   count,
  output logic [2*DATA_W-1:0]   latch,
  output logic                  flag,
  output logic                  set_p,
  output logic                  clr_p
);
  localparam int               CNT_W = 2*DATA_W;
  localparam logic [CNT_W-1:0] ALL1  = {CNT_W{1'b1}};

  logic armed;
  logic cont_eff;
  logic expire;

  assign cont_eff = CAN_CONT ? cont_mode : 1'b0;
  assign expire   = tick && (count == '0) && (armed || cont_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= ALL1;
      count <= ALL1;
      armed <= RESET_ARMED;
      flag  <= 1'b0;
      set_p <= 1'b0;
      clr_p <= 1'b0;
    end else begin
      set_p <= 1'b0;
      clr_p <= 1'b0;
      if (wr_lo) latch[DATA_W-1:0] <= wdata;
      if (wr_hi_load) begin
        latch[CNT_W-1:DATA_W] <= wdata;
        count <= {wdata, latch[DATA_W-1:0]};
        armed <= 1'b1;
        flag  <= 1'b0;
        clr_p <= 1'b1;
      end else begin
        if (wr_hi_latch) latch[CNT_W-1:DATA_W] <= wdata;
        if (tick) begin
          if (cont_eff && count == ALL1) count <= latch;
          else                           count <= count - 1'b1;
        end
        if (expire) begin
          flag  <= 1'b1;
          set_p <= 1'b1;
          if (!cont_eff) armed <= 1'b0;
        end else if (ack || wr_hi_latch) begin
          flag  <= 1'b0;
          clr_p <= 1'b1;
        end
      end
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    wr_hi_load |=> (count == {$past(wdata), $past(latch[DATA_W-1:0])}) && !flag); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_hi_load) |=> $stable(count)); // R10
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && cont_eff && count == ALL1 && !wr_hi_load) |=> count == $past(latch)); // R1
  AST_SET_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    set_p |-> flag); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((ack || wr_hi_latch) && !(tick && count == '0)) |=> !flag); // R5
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick_en,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [dit_pkg::ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  output logic [dit_pkg::NUM_TMR-1:0]   irq_flag,
  output logic [dit_pkg::NUM_TMR-1:0]   flag_set,
  output logic [dit_pkg::NUM_TMR-1:0]   flag_clr
);
  import dit_pkg::*;
  localparam int CNT_W = 2*DATA_W;

  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] latch_q;
  logic [NUM_TMR-1:0]            wr_lo, wr_hi_load, wr_hi_latch, rd_ack;
  logic                          mode_wr;
  logic [DATA_W-1:0]             mode_q;
  logic                          cont_mode;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data;
  end

  assign cont_mode = (mode_q[MODE_MSB:MODE_LSB] == MODE_CONT);

  dit_access_decode #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .cnt(cnt_q), .latch(latch_q), .mode_q(mode_q),
    .wr_lo(wr_lo), .wr_hi_load(wr_hi_load), .wr_hi_latch(wr_hi_latch),
    .rd_ack(rd_ack), .mode_wr(mode_wr), .rd_data(rd_data)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dit_counter #(
      .DATA_W(DATA_W), .CAN_CONT(i == 0), .RESET_ARMED(i == 0)
    ) cnt_i (
      .clk(clk), .rst(rst), .tick(tick_en), .cont_mode(cont_mode),
      .wr_lo(wr_lo[i]), .wr_hi_load(wr_hi_load[i]), .wr_hi_latch(wr_hi_latch[i]),
      .ack(rd_ack[i]), .wdata(wr_data),
      .count(cnt_q[i]), .latch(latch_q[i]),
      .flag(irq_flag[i]), .set_p(flag_set[i]), .clr_p(flag_clr[i])
    );
  end

  AST_T2_NO_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_T2_CHI) |=> $stable(latch_q[1][CNT_W-1:DATA_W])); // R7
endmodule

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] irq_flag, flag_set, flag_clr;

  int total = 0;
  int bad = 0;
  logic [7:0] d;
  logic [1:0] cap_set, cap_clr;

  always #2.5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_flag(irq_flag), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = v;
    @(negedge clk); wr_en = 1'b0; cap_set = flag_set; cap_clr = flag_clr;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data; cap_set = flag_set; cap_clr = flag_clr;
  endtask

  task automatic tick_n(input int n);
    if (n > 0) begin
      @(negedge clk); tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 flags", irq_flag, 0);
    rd(4'd0); check("R9 t1 cnt lo", d, 8'hFF);
    rd(4'd1); check("R9 t1 cnt hi", d, 8'hFF);
    rd(4'd2); check("R9 t1 latch lo", d, 8'hFF);
    rd(4'd3); check("R9 t1 latch hi", d, 8'hFF);
    rd(4'd4); check("R9 t2 cnt lo", d, 8'hFF);
    rd(4'd5); check("R9 t2 cnt hi", d, 8'hFF);
    rd(4'd6); check("R9 mode", d, 8'h00);
    rd(4'd8); check("R9 t2 latch lo", d, 8'hFF);
    rd(4'd9); check("R9 t2 latch hi", d, 8'hFF);
    rd(4'd7); check("R12 unused addr", d, 8'h00);

    // R10 no ticks, no movement
    repeat (20) @(negedge clk);
    rd(4'd0); check("R10 idle cnt lo", d, 8'hFF);

    // R1 continuous sweep
    wr(4'd6, 8'h40);
    rd(4'd6); check("R12 mode readback", d, 8'h40);
    for (int L = 0; L <= 10; L++) begin
      wr(4'd2, 8'(L)); wr(4'd1, 8'h00);
      check("R3 load clears flag", irq_flag[0], 0);
      tick_n(L);
      check("R1 no flag before L+1", irq_flag[0], 0);
      tick_n(1);
      check("R1 flag at L+1", irq_flag[0], 1);
      check("R11 set pulse", flag_set[0], 1);
      @(negedge clk);
      check("R11 set pulse one cycle", flag_set[0], 0);
      rd(4'd1); check("R5 hi read", d, 8'hFF);
      check("R5 hi read keeps flag", irq_flag[0], 1);
      rd(4'd0); check("R5 lo read", d, 8'hFF);
      check("R5 lo read clears flag", irq_flag[0], 0);
      check("R11 clear pulse", cap_clr[0], 1);
      tick_n(1);
      rd(4'd0); check("R1 reload value", d, L);
      tick_n(L);
      check("R1 no flag before period", irq_flag[0], 0);
      tick_n(1);
      check("R1 flag after L+2", irq_flag[0], 1);
    end

    // R11 expiry and acknowledge in the same cycle (latch 10, count now FFFF)
    rd(4'd0);
    tick_n(1);
    tick_n(10);
    @(negedge clk); tick_en = 1'b1; rd_en = 1'b1; addr = 4'd0;
    @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
    check("R12 pre-edge count", rd_data, 8'h00);
    check("R11 expiry beats ack", irq_flag[0], 1);
    check("R11 set pulse on collision", flag_set[0], 1);

    // R2 low-byte writes do not touch the count
    wr(4'd6, 8'h00);
    wr(4'd2, 8'h07); wr(4'd1, 8'h00);
    wr(4'd0, 8'h9A);
    rd(4'd0); check("R2 cnt lo unchanged", d, 8'h07);
    rd(4'd2); check("R2 latch lo via addr0", d, 8'h9A);
    wr(4'd2, 8'h33);
    rd(4'd0); check("R2 cnt lo unchanged 2", d, 8'h07);
    rd(4'd1); check("R2 cnt hi unchanged", d, 8'h00);
    rd(4'd2); check("R2 latch lo via addr2", d, 8'h33);

    // R4 latch-high write: clears flag, no reload
    tick_n(8);
    check("R6 one-shot flag", irq_flag[0], 1);
    wr(4'd3, 8'h5C);
    check("R4 flag cleared", irq_flag[0], 0);
    check("R11 clear pulse on latch hi", cap_clr[0], 1);
    rd(4'd3); check("R4 latch hi", d, 8'h5C);
    rd(4'd1); check("R4 cnt hi unchanged", d, 8'hFF);
    rd(4'd0); check("R4 cnt lo unchanged", d, 8'hFF);

    // R3 counter-high write loads full latch
    wr(4'd1, 8'h12);
    rd(4'd1); check("R3 cnt hi", d, 8'h12);
    rd(4'd0); check("R3 cnt lo", d, 8'h33);

    // R6 one-shot with mode 11
    wr(4'd6, 8'hC0);
    wr(4'd2, 8'h03); wr(4'd1, 8'h00);
    tick_n(4);
    check("R6 flag once", irq_flag[0], 1);
    rd(4'd0); check("R6 wrap value", d, 8'hFF);
    tick_n(1);
    rd(4'd1); check("R6 no reload hi", d, 8'hFF);
    rd(4'd0); check("R6 no reload lo", d, 8'hFE);
    tick_n(65535);
    check("R6 no second flag", irq_flag[0], 0);
    rd(4'd0); check("R6 full wrap lo", d, 8'hFF);

    // R7 / R8 timer 2 sweep
    for (int L = 0; L <= 6; L++) begin
      wr(4'd4, 8'(L)); wr(4'd5, 8'h00);
      check("R7 load clears flag", irq_flag[1], 0);
      rd(4'd8); check("R7 latch lo", d, L);
      rd(4'd9); check("R7 latch hi", d, 8'h00);
      tick_n(L);
      check("R7 no flag before L+1", irq_flag[1], 0);
      tick_n(1);
      check("R7 flag at L+1", irq_flag[1], 1);
      check("R11 t2 set pulse", flag_set[1], 1);
      rd(4'd5); check("R8 hi read", d, 8'hFF);
      check("R8 hi read keeps flag", irq_flag[1], 1);
      rd(4'd4); check("R8 lo read", d, 8'hFF);
      check("R8 lo read clears flag", irq_flag[1], 0);
      tick_n(1);
      rd(4'd4); check("R7 no reload", d, 8'hFE);
      check("R7 no second flag", irq_flag[1], 0);
    end
    wr(4'd4, 8'h55);
    rd(4'd4); check("R7 lo write keeps count", d, 8'hFE);
    rd(4'd8); check("R7 lo write sets latch", d, 8'h55);
    repeat (10) @(negedge clk);
    rd(4'd4); check("R10 t2 idle", d, 8'hFE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule